// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two 16-bit buses, called A and B, through two independent 8-bit lanes. Each lane moves data in one direction at a time. It either passes the live word from the opposite bus straight through, or it drives a word that it captured earlier. Every lane has two holding registers. One samples its slice of bus A and the other samples its slice of bus B. Each register loads on a rising edge of its own strobe, and it loads whatever the enable and direction settings are.

The pads are modelled as split vectors: an input word, an output word and one output-enable bit per lane for each bus. The surrounding pad ring combines these into tri-state pins. Tying the two lanes' controls together makes the block work as a single 16-bit transceiver. Driving them separately lets the two lanes move data in opposite directions at the same time.

All registers sit in one clock domain with a synchronous active-high reset. The pass-through paths are purely combinational.

Top module: `bidir_lane_xcvr`

## Requirements
- R1: When a lane's active-low enable `iso_n` is 1, both `a_oe` and `b_oe` for that lane are 0.
- R2: When `iso_n` is 0, a `to_b` value of 1 sets the lane's `b_oe` to 1 and `a_oe` to 0. A `to_b` value of 0 sets `a_oe` to 1 and `b_oe` to 0.
- R3: While a lane drives bus B and its `pick_ab` is 0, that lane's `b_out` slice equals its `a_in` slice in the same cycle.
- R4: While a lane drives bus B and its `pick_ab` is 1, that lane's `b_out` slice equals the lane's stored A-side word.
- R5: While a lane drives bus A and its `pick_ba` is 0, that lane's `a_out` slice equals its `b_in` slice in the same cycle.
- R6: While a lane drives bus A and its `pick_ba` is 1, that lane's `a_out` slice equals the lane's stored B-side word.
- R7: A lane's A-side (B-side) register loads the lane's `a_in` (`b_in`) slice at a clock edge where `load_a` (`load_b`) is sampled 1 and was sampled 0 at the previous edge. A strobe that is held at 1 loads only once.
- R8: A load happens regardless of `iso_n`, `to_b` and the pick inputs, including while the lane is isolated.
- R9: A synchronous reset clears all four lane registers and the strobe history to zero. The live pass-through paths keep working while reset is held.
- R10: Lane 0 uses bits 7:0 and lane 1 uses bits 15:8 of every data vector. Bit index n of each control vector belongs to lane n. A lane's controls and strobes never affect the other lane.
- R11: A bus output slice whose output-enable is 0 reads all zeros.
- R12: In stored mode, a word loaded at a clock edge is on the output bus from that edge onward, with no extra cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| iso_n | input | 2 | Per-lane enable, active low (1 = isolate) |
| to_b | input | 2 | Per-lane direction (1 = drive B, 0 = drive A) |
| pick_ab | input | 2 | Per-lane source for bus B (0 = live A, 1 = stored A) |
| pick_ba | input | 2 | Per-lane source for bus A (0 = live B, 1 = stored B) |
| load_a | input | 2 | Per-lane load strobe for the A-side register |
| load_b | input | 2 | Per-lane load strobe for the B-side register |
| a_in | input | 16 | Bus A pad input |
| b_in | input | 16 | Bus B pad input |
| a_out | output | 16 | Bus A pad output value |
| b_out | output | 16 | Bus B pad output value |
| a_oe | output | 2 | Per-lane bus A output enable |
| b_oe | output | 2 | Per-lane bus B output enable |

## Verification
A corrupted holding register stays invisible until its lane is switched to stored mode in the matching direction. From that point the bad word shows on the output bus in the same cycle. An error in the strobe history shows up one clock after the bad edge: either a missed load or an extra load, seen through the stored path. A direction or enable decode fault shows immediately on the output-enable pins. The register checks therefore read every stored word back through its stored path, in both lanes, with the lanes set to opposite directions.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  // Direction encoding for one lane: which bus the lane drives.
  typedef enum logic {
    XFER_TO_A = 1'b0,
    XFER_TO_B = 1'b1
  } xfer_dir_e;

  // Source encoding for one output path.
  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } xfer_src_e;

  // Lane output-enable decode for bus B.
  function automatic logic drives_b(input logic iso_n, input xfer_dir_e dir);
    return !iso_n && (dir == XFER_TO_B);
  endfunction

  // Lane output-enable decode for bus A.
  function automatic logic drives_a(input logic iso_n, input xfer_dir_e dir);
    return !iso_n && (dir == XFER_TO_A);
  endfunction

  // A load fires when the present strobe sample is high and the last one was low.
  function automatic logic load_fires(input logic now_s, input logic last_s);
    return now_s && !last_s;
  endfunction

endpackage

// File: rtl/xcvr_rise_det.sv
module xcvr_rise_det #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] strobe,
  output logic [N-1:0] fire
);
  import xcvr_pkg::*;

  logic [N-1:0] last_q;

  always_ff @(posedge clk) begin
    if (rst) last_q <= '0;
    else     last_q <= strobe;
  end

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign fire[i] = rst ? 1'b0 : load_fires(strobe[i], last_q[i]);
  end
endmodule

// File: rtl/xcvr_lane_store.sv
module xcvr_lane_store #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (cap) q <= d;
  end
endmodule

// File: rtl/xcvr_lane_route.sv
module xcvr_lane_route #(
  parameter int W = 8
) (
  input  logic         iso_n,
  input  logic         to_b,
  input  logic         pick_ab,
  input  logic         pick_ba,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic [W-1:0] held_a,
  input  logic [W-1:0] held_b,
  output logic [W-1:0] a_out,
  output logic [W-1:0] b_out,
  output logic         a_oe,
  output logic         b_oe
);
  import xcvr_pkg::*;

  function automatic logic [W-1:0] pick_word(input xfer_src_e src,
                                             input logic [W-1:0] live,
                                             input logic [W-1:0] held);
    return (src == SRC_STORED) ? held : live;
  endfunction

  xfer_dir_e dir;
  assign dir  = xfer_dir_e'(to_b);
  assign b_oe = drives_b(iso_n, dir);
  assign a_oe = drives_a(iso_n, dir);

  assign b_out = b_oe ? pick_word(xfer_src_e'(pick_ab), a_in, held_a) : '0;
  assign a_out = a_oe ? pick_word(xfer_src_e'(pick_ba), b_in, held_b) : '0;
endmodule

// File: rtl/bidir_lane_xcvr.sv
module bidir_lane_xcvr #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [LANES-1:0]          iso_n,
  input  logic [LANES-1:0]          to_b,
  input  logic [LANES-1:0]          pick_ab,
  input  logic [LANES-1:0]          pick_ba,
  input  logic [LANES-1:0]          load_a,
  input  logic [LANES-1:0]          load_b,
  input  logic [LANES*LANE_W-1:0]   a_in,
  input  logic [LANES*LANE_W-1:0]   b_in,
  output logic [LANES*LANE_W-1:0]   a_out,
  output logic [LANES*LANE_W-1:0]   b_out,
  output logic [LANES-1:0]          a_oe,
  output logic [LANES-1:0]          b_oe
);
  localparam int BUS_W = LANES * LANE_W;

  // Named internal events, visible to the bound checker.
  logic [LANES-1:0] cap_a_evt;
  logic [LANES-1:0] cap_b_evt;
  logic [BUS_W-1:0] lane_reg_a;
  logic [BUS_W-1:0] lane_reg_b;

  xcvr_rise_det #(.N(LANES)) u_edge_a (
    .clk(clk), .rst(rst), .strobe(load_a), .fire(cap_a_evt)
  );
  xcvr_rise_det #(.N(LANES)) u_edge_b (
    .clk(clk), .rst(rst), .strobe(load_b), .fire(cap_b_evt)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    xcvr_lane_store #(.W(LANE_W)) u_store_a (
      .clk(clk), .rst(rst), .cap(cap_a_evt[l]),
      .d(a_in[l*LANE_W +: LANE_W]), .q(lane_reg_a[l*LANE_W +: LANE_W])
    );
    xcvr_lane_store #(.W(LANE_W)) u_store_b (
      .clk(clk), .rst(rst), .cap(cap_b_evt[l]),
      .d(b_in[l*LANE_W +: LANE_W]), .q(lane_reg_b[l*LANE_W +: LANE_W])
    );
    xcvr_lane_route #(.W(LANE_W)) u_route (
      .iso_n(iso_n[l]), .to_b(to_b[l]),
      .pick_ab(pick_ab[l]), .pick_ba(pick_ba[l]),
      .a_in(a_in[l*LANE_W +: LANE_W]), .b_in(b_in[l*LANE_W +: LANE_W]),
      .held_a(lane_reg_a[l*LANE_W +: LANE_W]),
      .held_b(lane_reg_b[l*LANE_W +: LANE_W]),
      .a_out(a_out[l*LANE_W +: LANE_W]), .b_out(b_out[l*LANE_W +: LANE_W]),
      .a_oe(a_oe[l]), .b_oe(b_oe[l])
    );
  end
endmodule

// File: rtl/bidir_lane_xcvr_chk.sv
module bidir_lane_xcvr_chk #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic [LANES-1:0]        iso_n,
  input logic [LANES-1:0]        to_b,
  input logic [LANES-1:0]        pick_ab,
  input logic [LANES-1:0]        pick_ba,
  input logic [LANES*LANE_W-1:0] a_in,
  input logic [LANES*LANE_W-1:0] b_in,
  input logic [LANES*LANE_W-1:0] a_out,
  input logic [LANES*LANE_W-1:0] b_out,
  input logic [LANES-1:0]        a_oe,
  input logic [LANES-1:0]        b_oe,
  input logic [LANES-1:0]        cap_a,
  input logic [LANES-1:0]        cap_b,
  input logic [LANES*LANE_W-1:0] reg_a,
  input logic [LANES*LANE_W-1:0] reg_b
);
  // R9
  rst_clear_chk: assert property (@(posedge clk) rst |=> (reg_a == '0) && (reg_b == '0));

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    // R1
    iso_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      iso_n[l] |-> (!a_oe[l] && !b_oe[l]));
    // R2
    dir_to_b_chk: assert property (@(posedge clk) disable iff (rst)
      (!iso_n[l] && to_b[l]) |-> (b_oe[l] && !a_oe[l]));
    // R2
    dir_to_a_chk: assert property (@(posedge clk) disable iff (rst)
      (!iso_n[l] && !to_b[l]) |-> (a_oe[l] && !b_oe[l]));
    // R3
    live_ab_chk: assert property (@(posedge clk) disable iff (rst)
      (b_oe[l] && !pick_ab[l]) |-> (b_out[l*LANE_W +: LANE_W] == a_in[l*LANE_W +: LANE_W]));
    // R4
    held_ab_chk: assert property (@(posedge clk) disable iff (rst)
      (b_oe[l] && pick_ab[l]) |-> (b_out[l*LANE_W +: LANE_W] == reg_a[l*LANE_W +: LANE_W]));
    // R5
    live_ba_chk: assert property (@(posedge clk) disable iff (rst)
      (a_oe[l] && !pick_ba[l]) |-> (a_out[l*LANE_W +: LANE_W] == b_in[l*LANE_W +: LANE_W]));
    // R6
    held_ba_chk: assert property (@(posedge clk) disable iff (rst)
      (a_oe[l] && pick_ba[l]) |-> (a_out[l*LANE_W +: LANE_W] == reg_b[l*LANE_W +: LANE_W]));
    // R7
    load_a_chk: assert property (@(posedge clk) disable iff (rst)
      cap_a[l] |=> (reg_a[l*LANE_W +: LANE_W] == $past(a_in[l*LANE_W +: LANE_W])));
    // R7
    load_b_chk: assert property (@(posedge clk) disable iff (rst)
      cap_b[l] |=> (reg_b[l*LANE_W +: LANE_W] == $past(b_in[l*LANE_W +: LANE_W])));
    // R7
    keep_a_chk: assert property (@(posedge clk) disable iff (rst)
      !cap_a[l] |=> $stable(reg_a[l*LANE_W +: LANE_W]));
    // R7
    keep_b_chk: assert property (@(posedge clk) disable iff (rst)
      !cap_b[l] |=> $stable(reg_b[l*LANE_W +: LANE_W]));
    // R11
    idle_b_chk: assert property (@(posedge clk) disable iff (rst)
      !b_oe[l] |-> (b_out[l*LANE_W +: LANE_W] == '0));
    // R11
    idle_a_chk: assert property (@(posedge clk) disable iff (rst)
      !a_oe[l] |-> (a_out[l*LANE_W +: LANE_W] == '0));
  end
endmodule

bind bidir_lane_xcvr bidir_lane_xcvr_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
  .clk(clk), .rst(rst), .iso_n(iso_n), .to_b(to_b),
  .pick_ab(pick_ab), .pick_ba(pick_ba),
  .a_in(a_in), .b_in(b_in), .a_out(a_out), .b_out(b_out),
  .a_oe(a_oe), .b_oe(b_oe),
  .cap_a(cap_a_evt), .cap_b(cap_b_evt),
  .reg_a(lane_reg_a), .reg_b(lane_reg_b)
);

// File: tb/bidir_lane_xcvr_bench.sv
module bidir_lane_xcvr_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;

  // ctl = {iso_n1,to_b1,pick_ab1,pick_ba1, iso_n0,to_b0,pick_ab0,pick_ba0}
  // oe  = {a_oe1,b_oe1,a_oe0,b_oe0}
  typedef struct packed {
    logic [7:0]  ctl;
    logic [15:0] ain;
    logic [15:0] bin;
    logic [15:0] exp_a;
    logic [15:0] exp_b;
    logic [3:0]  exp_oe;
  } vec_t;

  // Registers are preloaded with A-side 5A3C and B-side A5C3 before the walk.
  localparam vec_t VECS [NVEC] = '{
    {8'b1000_1000, 16'h1234, 16'hABCD, 16'h0000, 16'h0000, 4'b0000}, // R1 R11
    {8'b0100_0100, 16'h1234, 16'hABCD, 16'h0000, 16'h1234, 4'b0101}, // R2 R3
    {8'b0110_0110, 16'h1234, 16'hABCD, 16'h0000, 16'h5A3C, 4'b0101}, // R4
    {8'b0000_0000, 16'h1234, 16'hABCD, 16'hABCD, 16'h0000, 4'b1010}, // R2 R5
    {8'b0001_0001, 16'h1234, 16'hABCD, 16'hA5C3, 16'h0000, 4'b1010}, // R6
    {8'b0110_0000, 16'h1234, 16'hABCD, 16'h00CD, 16'h5A00, 4'b0110}, // R10
    {8'b0001_0100, 16'hF00F, 16'h0FF0, 16'hA500, 16'h000F, 4'b1001}, // R10
    {8'b0101_1011, 16'h1234, 16'hABCD, 16'h0000, 16'h1200, 4'b0100}  // R1 R10
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  iso_n = 2'b11, to_b = 2'b00, pick_ab = 2'b00, pick_ba = 2'b00;
  logic [1:0]  load_a = 2'b00, load_b = 2'b00;
  logic [15:0] a_in = '0, b_in = '0;
  logic [15:0] a_out, b_out;
  logic [1:0]  a_oe, b_oe;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bidir_lane_xcvr u_bidir_lane_xcvr (
    .clk(clk), .rst(rst), .iso_n(iso_n), .to_b(to_b),
    .pick_ab(pick_ab), .pick_ba(pick_ba), .load_a(load_a), .load_b(load_b),
    .a_in(a_in), .b_in(b_in), .a_out(a_out), .b_out(b_out),
    .a_oe(a_oe), .b_oe(b_oe)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_ctl(input logic [7:0] c);
    iso_n   = {c[7], c[3]};
    to_b    = {c[6], c[2]};
    pick_ab = {c[5], c[1]};
    pick_ba = {c[4], c[0]};
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R9: reset state seen through both stored paths
    set_ctl(8'b0110_0110); #1;
    check("R9 stored A after reset", b_out, 16'h0000);
    set_ctl(8'b0001_0001); #1;
    check("R9 stored B after reset", a_out, 16'h0000);

    // R8 R7: preload while isolated
    set_ctl(8'b1111_1111);
    a_in = 16'h5A3C; b_in = 16'hA5C3; load_a = 2'b11; load_b = 2'b11;
    @(negedge clk);
    load_a = 2'b00; load_b = 2'b00; a_in = 16'h0000; b_in = 16'h0000;
    check("R8 oe while isolated", {12'h0, a_oe[1], b_oe[1], a_oe[0], b_oe[0]}, 16'h0000);
    set_ctl(8'b0110_0110); #1;
    check("R8 A load while isolated", b_out, 16'h5A3C);
    set_ctl(8'b0001_0001); #1;
    check("R8 B load while isolated", a_out, 16'hA5C3);

    // Table walk
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      set_ctl(VECS[i].ctl); a_in = VECS[i].ain; b_in = VECS[i].bin;
      #1;
      check($sformatf("R1-6,10,11 vec%0d a_out", i), a_out, VECS[i].exp_a);
      check($sformatf("R10 vec%0d b_out", i), b_out, VECS[i].exp_b);
      check($sformatf("R2 vec%0d oe", i), {12'h0, a_oe[1], b_oe[1], a_oe[0], b_oe[0]},
            {12'h0, VECS[i].exp_oe});
    end

    // R12 R4: capture while driving B in stored mode shows from the same edge
    @(negedge clk);
    set_ctl(8'b0110_0110); a_in = 16'h7788; load_a = 2'b11;
    #1 check("R12 before edge", b_out, 16'h5A3C);
    @(negedge clk);
    check("R12 after edge", b_out, 16'h7788);

    // R7: strobe held high loads only once
    a_in = 16'h1111;
    repeat (3) @(negedge clk);
    check("R7 held strobe no reload", b_out, 16'h7788);
    load_a = 2'b00;
    @(negedge clk);
    check("R7 after strobe drop", b_out, 16'h7788);

    // R10: lane 1 strobe alone leaves lane 0 register untouched
    a_in = 16'h9922; load_a = 2'b10;
    @(negedge clk);
    load_a = 2'b00;
    check("R10 per-lane load", b_out, 16'h9988);

    // R8: B-side load while lane drives B (direction opposite)
    b_in = 16'h3344; load_b = 2'b11;
    @(negedge clk);
    load_b = 2'b00;
    set_ctl(8'b0001_0001); #1;
    check("R8 B load under other direction", a_out, 16'h3344);

    // R9: live path works while reset held; registers cleared
    @(negedge clk);
    rst = 1'b1; set_ctl(8'b0100_0100); a_in = 16'hBEEF;
    #1 check("R9 live path in reset", b_out, 16'hBEEF);
    @(negedge clk);
    rst = 1'b0;
    set_ctl(8'b0110_0110); #1;
    check("R9 registers cleared", b_out, 16'h0000);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule